// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a sticky record of which reset sources have fired since software last cleared the record. Five single-cycle event inputs report a power-on reset, an external pin reset, a brown-out reset, a watchdog reset and a USB bus reset. Each event sets its own flag in an 8-bit status byte. Software reads the byte through a read port. It writes zero to a flag to clear it. Writing one to a flag leaves it unchanged.

A power-on event sets the power-on flag and wipes every other flag. No reset clears the power-on flag. Only a software write of zero to bit 0 clears it. Any other flags left set therefore name the reset that happened after the last power-on.

Top module: `rst_cause_reg`

## Requirements
- R1: Bit positions are fixed: bit 0 power-on, bit 1 external, bit 2 brown-out, bit 3 watchdog, bit 5 USB bus reset. After `rst_n` is deasserted, all bits read zero until an event occurs.
- R2: A pulse on `ext_evt`, `bod_evt`, `wdt_evt` or `usb_evt` sets its flag on the next clock edge. The flag stays set until it is cleared.
- R3: A pulse on `por_evt` sets bit 0 and clears bits 1, 2, 3 and 5 on the next clock edge.
- R4: A write with `wr_en` high clears every flag whose `wr_data` bit is 0. Flags whose `wr_data` bit is 1 keep their value.
- R5: Bit 0 changes only for two reasons: it is set by `por_evt`, or it is cleared by a software write of zero. No other event affects it.
- R6: Bits 4, 6 and 7 always read zero. Writes to these bits have no effect.
- R7: If a source event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: If `por_evt` and any other source event arrive in the same cycle, only bit 0 ends up set. This holds even if a write arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low register reset, used at initial bring-up |
| por_evt | input | 1 | Power-on reset event pulse |
| ext_evt | input | 1 | External pin reset event pulse |
| bod_evt | input | 1 | Brown-out reset event pulse |
| wdt_evt | input | 1 | Watchdog reset event pulse |
| usb_evt | input | 1 | USB bus reset event pulse |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Write data; a 0 clears the matching flag |
| rd_data | output | 8 | Current flag byte |

## Verification
Two functions can land on the same edge: a source event setting a flag, and a software write clearing it. Power-on wiping can also coincide with both. The bench provokes every such collision by sweeping all 32 event combinations against a range of write values, starting each vector from a preloaded flag byte. It compares the result on the next edge with a value it computes arithmetically. In that computation, power-on overrides everything, then sets take precedence over clears, and the reserved bits are masked to zero.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_evt,
  input  logic       ext_evt,
  input  logic       bod_evt,
  input  logic       wdt_evt,
  input  logic       usb_evt,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  localparam logic [7:0] LIVE = 8'b0010_1111;

  logic [7:0] flags, evt, kept, nxt;

  assign evt  = {2'b00, usb_evt, 1'b0, wdt_evt, bod_evt, ext_evt, por_evt};
  assign kept = wr_en ? (flags & wr_data) : flags;
  assign nxt  = por_evt ? 8'h01 : ((kept | evt) & LIVE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= 8'h00;
    else        flags <= nxt;

  assign rd_data = flags;

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE) == 8'h00);
  a_r3_por_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> rd_data == 8'h01);
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_evt && !por_evt) |=> rd_data[3]);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_evt && wr_en && !wr_data[1] && !por_evt) |=> rd_data[1]);
  a_r5_por_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_evt && !(wr_en && !wr_data[0])) |=> $stable(rd_data[0]));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[5] && !usb_evt && !por_evt) |=> !rd_data[5]);
endmodule

// File: tb/rst_cause_reg_test.sv
module rst_cause_reg_test;
  logic clk = 0, rst_n = 0;
  logic por_evt = 0, ext_evt = 0, bod_evt = 0, wdt_evt = 0, usb_evt = 0;
  logic wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  int vectors = 0, errs = 0;
  logic [7:0] model;

  rst_cause_reg uut (.*);

  always #2 clk = ~clk;

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  task automatic check(string req, logic [7:0] exp);
    vectors++;
    if (rd_data !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic apply(logic [4:0] e, logic we, logic [7:0] wd);
    @(negedge clk);
    {usb_evt, wdt_evt, bod_evt, ext_evt, por_evt} = e;
    wr_en = we; wr_data = wd;
    @(negedge clk);
    {usb_evt, wdt_evt, bod_evt, ext_evt, por_evt} = 0;
    wr_en = 0;
  endtask

  function automatic logic [7:0] predict(logic [7:0] cur, logic [4:0] e, logic we, logic [7:0] wd);
    logic [7:0] ev, k;
    if (e[0]) return 8'h01;
    ev = {2'b00, e[4], 1'b0, e[3:1], 1'b0};
    k = we ? (cur & wd) : cur;
    return (k | ev) & 8'h2F;
  endfunction

  function automatic logic [7:0] pre_of(int i);
    logic [7:0] v;
    v = 8'(i * 37);
    return v & 8'h2F;
  endfunction

  initial begin
    #9;
    check("R1", 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1", 8'h00);
    apply(5'b00010, 0, 0); check("R2", 8'h02);
    apply(5'b00100, 0, 0); check("R2", 8'h06);
    apply(5'b01000, 0, 0); check("R2", 8'h0E);
    apply(5'b10000, 0, 0); check("R2", 8'h2E);
    apply(5'b00000, 0, 0); check("R2", 8'h2E);
    apply(5'b00001, 0, 0); check("R3", 8'h01);
    apply(5'b01110, 0, 0); check("R5", 8'h0F);
    apply(5'b00000, 1, 8'hFE); check("R5", 8'h0E);
    apply(5'b00000, 1, 8'hFF); check("R6", 8'h0E);
    apply(5'b00000, 1, 8'hFB); check("R4", 8'h0A);
    apply(5'b00010, 1, 8'h00); check("R7", 8'h02);
    apply(5'b11111, 1, 8'h00); check("R8", 8'h01);
    for (int e = 0; e < 32; e++)
      for (int w = 0; w < 20; w++) begin
        logic [7:0] pre, wd;
        logic we;
        pre = pre_of(e * 20 + w);
        wd = 8'(w * 53 + e);
        we = (w % 3) != 0;
        apply(5'b00001, 0, 0);
        apply(5'b00000, 1, 8'h00);
        apply({pre[5], pre[3:1], 1'b0}, 0, 0);
        if (pre[0]) begin
          apply(5'b00001, 0, 0);
          apply({pre[5], pre[3:1], 1'b0}, 0, 0);
        end
        check("R1", pre);
        model = predict(pre, 5'(e), we, wd);
        apply(5'(e), we, wd);
        check(e[0] ? "R8" : (we ? "R7" : "R2"), model);
      end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule